// File: doc/BRIEF.md
# Package Sleep State Controller

This block follows the power state of a processor package that carries two hardware threads. Each thread reports its own idle depth. The block combines the two reports into one package request, which is always the shallower of the two. A set of active-low stop, sleep, deep-sleep and deeper-sleep pins then moves the package through the clock-stopped states. The pins must arrive in a fixed order, and each stage is entered only from the stage just above it. Any pin that arrives out of order, and any bus activity while clocks are stopped, sets a sticky protocol-violation flag.

While the package is in Stop-Grant it still accepts snoops and wake sources. These are SMI, INIT, two local interrupt lines and a monitor event. A latched source raises a break-event output that asks the system to bring the package back to Normal. When the package reaches Normal again, each latched source is handed on exactly once as a one-cycle pulse. In the deepest state the block selects a voltage code. An enhanced voltage code is allowed only when the cache reports that every way is powered down. After the deep-sleep pin is released, a programmable settle count of bus clocks must elapse before the package counts as Sleep again.

Clock gating, the PLL and the generation of bus cycles are handled elsewhere. The stop-grant acknowledge cycle appears here only as a completion input.

Top module: `pkg_sleep_ctrl`

## Requirements
- R1: `pkg_req` is combinational from the two thread inputs. The thread codes are C0=0, C1=1, C2=2 and C4=3. The shallower of the two codes decides the request: C0 gives 0 (Normal), C1 gives 1 (AutoHalt), C2 gives 2 (Stop-Grant) and C4 gives 6 (Deeper Sleep).
- R2: `pkg_state` uses the codes Normal 0, AutoHalt 1, Stop-Grant 2, Stop-Grant Snoop 3, Sleep 4, Deep Sleep 5, Deeper 6 and Deeper-Enhanced 7. While no stop entry happens, the state moves to Normal one clock after a request of Normal, and to AutoHalt for any other request.
- R3: From Normal or AutoHalt, a clock edge that sees `stop_clk_n` low together with `sga_done` moves the state to Stop-Grant. This one-clock entry is far inside the 1384-clock limit. Without `sga_done` the state does not move. When `stop_clk_n` goes high in Stop-Grant, the state returns to the state it held before entry.
- R4: In Stop-Grant, `snoop_req` or a wake source not yet latched moves the state to Stop-Grant Snoop. The state returns to Stop-Grant on `snoop_done` after a snoop. After an interrupt alone, it returns one clock later. A source that is already latched causes no snoop state.
- R5: `sleep_n` low in Stop-Grant moves the state to Sleep, and `sleep_n` high in Sleep moves it back to Stop-Grant. `sleep_n` low in Normal, AutoHalt or Stop-Grant Snoop sets `violation` and does not enter Sleep.
- R6: `deep_n` low in Sleep moves the state to Deep Sleep. After `deep_n` rises, the state becomes Sleep after SETTLE_CYC clock edges with `deep_n` high, and not earlier.
- R7: `deeper_n` low in Deep Sleep gives Deeper-Enhanced if `ways_zero` is set, and Deeper otherwise. The choice is re-evaluated every clock while `deeper_n` stays low. `vid_sel` is 0 for nominal, 1 for Deeper and 2 for Deeper-Enhanced. `deeper_n` high in either Deeper state returns the state to Deep Sleep.
- R8: `break_evt` is high in Stop-Grant and in Stop-Grant Snoop from the clock after any wake source is latched. No interrupt-enable mask is considered.
- R9: The bits of `wake_src` and `evt_fire` are: bit0 SMI, bit1 INIT, bits 2 to LINT_W+1 the local interrupt lines, and the top bit the monitor event. Sources are latched only in Stop-Grant and in Stop-Grant Snoop. On the clock after the state reaches Normal, `evt_fire` pulses the latched set for exactly one cycle.
- R10: In Sleep, Deep Sleep and the two Deeper states, snoops and wake sources are not latched and do not change the state. A snoop or any change of `wake_src` seen there sets `violation`.
- R11: Synchronous reset gives state Normal, `violation` 0, `break_evt` 0, `evt_fire` 0 and `vid_sel` 0, and clears every latched source.
- R12: `violation` stays set until reset. A legal pass down to the Deeper state and back up leaves it clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| thr0_cst | input | 2 | Idle state of thread 0 |
| thr1_cst | input | 2 | Idle state of thread 1 |
| stop_clk_n | input | 1 | Stop-clock request, active low |
| sleep_n | input | 1 | Sleep request, active low |
| deep_n | input | 1 | Deep-sleep request, active low |
| deeper_n | input | 1 | Deeper-sleep request, active low |
| sga_done | input | 1 | Stop-grant acknowledge response complete |
| snoop_req | input | 1 | Bus snoop arriving |
| snoop_done | input | 1 | Pending snoop serviced |
| wake_src | input | LINT_W+3 | Wake sources: SMI, INIT, local lines, monitor |
| ways_zero | input | 1 | All cache ways are shut down |
| pkg_req | output | 3 | Package state requested by the threads |
| pkg_state | output | 3 | Current package state |
| break_evt | output | 1 | Pending break event while in Stop-Grant |
| vid_sel | output | 2 | Voltage code select |
| violation | output | 1 | Sticky protocol-violation flag |
| evt_fire | output | LINT_W+3 | One-shot release of the latched sources |

## Verification
All sixteen pairs of thread codes are driven. Each pair checks the combined request, which tells apart the shallower-wins rule from a rule that picks one thread. Each pair also checks the resulting Normal or AutoHalt base state. Stop-Grant is entered both from Normal and from AutoHalt, which shows that the exit goes back to the saved state and not to a fixed one. Inside Stop-Grant, a snoop, a new interrupt, a repeated interrupt and a monitor event separate the snoop wait, the one-cycle detour and the no-detour case. The deep pass is run with `ways_zero` both clear and set to tell the two voltage codes apart. The settle window is probed one clock before and at its end. Out-of-order pins and bus activity while clocks are stopped are driven to show that they set the flag without moving or latching anything.

// File: rtl/pss_pkg.sv
package pss_pkg;

    typedef enum logic [1:0] {
        TC0 = 2'd0,
        TC1 = 2'd1,
        TC2 = 2'd2,
        TC4 = 2'd3
    } tcstate_t;

    typedef enum logic [2:0] {
        PS_NORMAL     = 3'd0,
        PS_AUTOHALT   = 3'd1,
        PS_STOPGNT    = 3'd2,
        PS_SG_SNOOP   = 3'd3,
        PS_SLEEP      = 3'd4,
        PS_DEEP       = 3'd5,
        PS_DEEPER     = 3'd6,
        PS_DEEPER_ENH = 3'd7
    } pstate_t;

    typedef enum logic [1:0] {
        VID_NOM        = 2'd0,
        VID_DEEPER     = 2'd1,
        VID_DEEPER_ENH = 2'd2
    } vid_t;

    // The shallower thread decides the package request.
    function automatic pstate_t resolve_req(tcstate_t a, tcstate_t b);
        tcstate_t m;
        m = (a < b) ? a : b;
        case (m)
            TC0:     return PS_NORMAL;
            TC1:     return PS_AUTOHALT;
            TC2:     return PS_STOPGNT;
            default: return PS_DEEPER;
        endcase
    endfunction

    function automatic logic in_sg_family(pstate_t s);
        return (s == PS_STOPGNT) || (s == PS_SG_SNOOP);
    endfunction

    // Every state with a code of 4 or more has its clocks stopped.
    function automatic logic clocks_stopped(pstate_t s);
        return s[2];
    endfunction

    function automatic vid_t vid_of(pstate_t s);
        case (s)
            PS_DEEPER:     return VID_DEEPER;
            PS_DEEPER_ENH: return VID_DEEPER_ENH;
            default:       return VID_NOM;
        endcase
    endfunction

endpackage

// File: rtl/pss_resolve.sv
module pss_resolve
    import pss_pkg::*;
(
    input  logic [1:0] thr_a,
    input  logic [1:0] thr_b,
    output pstate_t    req
);
    always_comb begin
        req = resolve_req(tcstate_t'(thr_a), tcstate_t'(thr_b));
    end
endmodule

// File: rtl/pss_evt_latch.sv
module pss_evt_latch
    import pss_pkg::*;
#(
    parameter int NSRC = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  pstate_t         state,
    input  logic [NSRC-1:0] src,
    output logic            new_evt,
    output logic            src_changed,
    output logic            break_evt,
    output logic [NSRC-1:0] fire
);
    logic [NSRC-1:0] lat_q;
    logic [NSRC-1:0] src_q;

    always_comb begin
        new_evt     = in_sg_family(state) && (|(src & ~lat_q));
        src_changed = (src != src_q);
        break_evt   = in_sg_family(state) && (|lat_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
            src_q <= '0;
            fire  <= '0;
        end else begin
            src_q <= src;
            fire  <= '0;
            if (in_sg_family(state)) begin
                lat_q <= lat_q | src;
            end else if (state == PS_NORMAL) begin
                fire  <= lat_q;
                lat_q <= '0;
            end
        end
    end
endmodule

// File: rtl/pss_fsm.sv
module pss_fsm
    import pss_pkg::*;
#(
    parameter int SETTLE_CYC = 2000
) (
    input  logic    clk,
    input  logic    rst,
    input  pstate_t req,
    input  logic    stop_clk_n,
    input  logic    sleep_n,
    input  logic    deep_n,
    input  logic    deeper_n,
    input  logic    sga_done,
    input  logic    snoop_req,
    input  logic    snoop_done,
    input  logic    new_evt,
    input  logic    src_changed,
    input  logic    ways_zero,
    output pstate_t state,
    output logic    violation
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    pstate_t        state_q, nxt, prev_q, nprev;
    logic           snp_q, nsnp;
    logic [CW-1:0]  cnt_q, ncnt;
    logic           bad;

    always_comb begin
        nxt   = state_q;
        nprev = prev_q;
        nsnp  = snp_q;
        ncnt  = '0;
        case (state_q)
            PS_NORMAL, PS_AUTOHALT: begin
                if (!stop_clk_n && sga_done) begin
                    nxt   = PS_STOPGNT;
                    nprev = state_q;
                end else begin
                    nxt = (req == PS_NORMAL) ? PS_NORMAL : PS_AUTOHALT;
                end
            end
            PS_STOPGNT: begin
                if (snoop_req || new_evt) begin
                    nxt  = PS_SG_SNOOP;
                    nsnp = snoop_req;
                end else if (!sleep_n) begin
                    nxt = PS_SLEEP;
                end else if (stop_clk_n) begin
                    nxt = prev_q;
                end
            end
            PS_SG_SNOOP: begin
                if (!snp_q || snoop_done) begin
                    nxt  = PS_STOPGNT;
                    nsnp = 1'b0;
                end
            end
            PS_SLEEP: begin
                if (!deep_n)      nxt = PS_DEEP;
                else if (sleep_n) nxt = PS_STOPGNT;
            end
            PS_DEEP: begin
                if (!deeper_n) begin
                    nxt = ways_zero ? PS_DEEPER_ENH : PS_DEEPER;
                end else if (deep_n) begin
                    if (cnt_q == LAST) nxt = PS_SLEEP;
                    else               ncnt = cnt_q + 1'b1;
                end
            end
            default: begin
                if (deeper_n) nxt = PS_DEEP;
                else          nxt = ways_zero ? PS_DEEPER_ENH : PS_DEEPER;
            end
        endcase
    end

    // Out-of-order pin levels and bus activity while clocks are stopped.
    always_comb begin
        bad = 1'b0;
        if (!sleep_n && (state_q == PS_NORMAL || state_q == PS_AUTOHALT ||
                         state_q == PS_SG_SNOOP))
            bad = 1'b1;
        if (!deep_n && !clocks_stopped(state_q))
            bad = 1'b1;
        if (!deeper_n && !(state_q == PS_DEEP || state_q == PS_DEEPER ||
                           state_q == PS_DEEPER_ENH))
            bad = 1'b1;
        if (clocks_stopped(state_q) && (snoop_req || src_changed))
            bad = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= PS_NORMAL;
            prev_q    <= PS_NORMAL;
            snp_q     <= 1'b0;
            cnt_q     <= '0;
            violation <= 1'b0;
        end else begin
            state_q   <= nxt;
            prev_q    <= nprev;
            snp_q     <= nsnp;
            cnt_q     <= ncnt;
            violation <= violation | bad;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/pkg_sleep_ctrl.sv
module pkg_sleep_ctrl
    import pss_pkg::*;
#(
    parameter int LINT_W     = 2,
    parameter int SETTLE_CYC = 2000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          thr0_cst,
    input  logic [1:0]          thr1_cst,
    input  logic                stop_clk_n,
    input  logic                sleep_n,
    input  logic                deep_n,
    input  logic                deeper_n,
    input  logic                sga_done,
    input  logic                snoop_req,
    input  logic                snoop_done,
    input  logic [LINT_W+2:0]   wake_src,
    input  logic                ways_zero,
    output logic [2:0]          pkg_req,
    output logic [2:0]          pkg_state,
    output logic                break_evt,
    output logic [1:0]          vid_sel,
    output logic                violation,
    output logic [LINT_W+2:0]   evt_fire
);
    localparam int NSRC = LINT_W + 3;

    pstate_t req, state;
    logic    new_evt, src_changed;

    pss_resolve u_resolve (
        .thr_a (thr0_cst),
        .thr_b (thr1_cst),
        .req   (req)
    );

    pss_evt_latch #(.NSRC(NSRC)) u_latch (
        .clk         (clk),
        .rst         (rst),
        .state       (state),
        .src         (wake_src),
        .new_evt     (new_evt),
        .src_changed (src_changed),
        .break_evt   (break_evt),
        .fire        (evt_fire)
    );

    pss_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .stop_clk_n  (stop_clk_n),
        .sleep_n     (sleep_n),
        .deep_n      (deep_n),
        .deeper_n    (deeper_n),
        .sga_done    (sga_done),
        .snoop_req   (snoop_req),
        .snoop_done  (snoop_done),
        .new_evt     (new_evt),
        .src_changed (src_changed),
        .ways_zero   (ways_zero),
        .state       (state),
        .violation   (violation)
    );

    assign pkg_req   = req;
    assign pkg_state = state;
    assign vid_sel   = vid_of(state);
endmodule

// File: rtl/pkg_sleep_ctrl_chk.sv
module pkg_sleep_ctrl_chk #(
    parameter int NSRC = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            stop_clk_n,
    input logic            sga_done,
    input logic            sleep_n,
    input logic            deep_n,
    input logic            snoop_req,
    input logic [NSRC-1:0] wake_src,
    input logic            ways_zero,
    input logic [2:0]      pkg_state,
    input logic            break_evt,
    input logic            violation,
    input logic [NSRC-1:0] evt_fire
);
    assert_sg_entry_R3: assert property (@(posedge clk) disable iff (rst)
        ((pkg_state == 3'd0 || pkg_state == 3'd1) && !stop_clk_n && sga_done)
        |=> (pkg_state == 3'd2));

    assert_sleep_only_from_sg_R5: assert property (@(posedge clk) disable iff (rst)
        (pkg_state == 3'd0 || pkg_state == 3'd1 || pkg_state == 3'd3)
        |=> (pkg_state != 3'd4));

    assert_enh_needs_ways_R7: assert property (@(posedge clk) disable iff (rst)
        (pkg_state == 3'd7) |-> $past(ways_zero));

    assert_break_on_latch_R8: assert property (@(posedge clk) disable iff (rst)
        (pkg_state == 3'd2 && wake_src != '0 && sleep_n && !stop_clk_n)
        |=> break_evt);

    assert_fire_once_R9: assert property (@(posedge clk) disable iff (rst)
        (evt_fire != '0) |=> (evt_fire == '0));

    assert_sleep_ignore_R10: assert property (@(posedge clk) disable iff (rst)
        (pkg_state == 3'd4 && snoop_req && !sleep_n && deep_n)
        |=> (pkg_state == 3'd4 && violation));

    assert_viol_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        violation |=> violation);
endmodule

bind pkg_sleep_ctrl pkg_sleep_ctrl_chk #(.NSRC(NSRC)) u_chk (.*);

// File: tb/tb_pkg_sleep_ctrl.sv
`timescale 1ns/1ps
module tb_pkg_sleep_ctrl;
    localparam int LW = 2;
    localparam int NS = LW + 3;
    localparam int SETTLE = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    thr0 = '0, thr1 = '0;
    logic          stop_n = 1'b1, slp_n = 1'b1, dslp_n = 1'b1, drst_n = 1'b1;
    logic          sga = 1'b0, snp = 1'b0, snpd = 1'b0, wz = 1'b0;
    logic [NS-1:0] src = '0;
    logic [2:0]    preq, pst;
    logic          brk, viol;
    logic [1:0]    vid;
    logic [NS-1:0] fire;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pkg_sleep_ctrl #(.LINT_W(LW), .SETTLE_CYC(SETTLE)) dut (
        .clk(clk), .rst(rst), .thr0_cst(thr0), .thr1_cst(thr1),
        .stop_clk_n(stop_n), .sleep_n(slp_n), .deep_n(dslp_n), .deeper_n(drst_n),
        .sga_done(sga), .snoop_req(snp), .snoop_done(snpd), .wake_src(src),
        .ways_zero(wz), .pkg_req(preq), .pkg_state(pst), .break_evt(brk),
        .vid_sel(vid), .violation(viol), .evt_fire(fire)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        chk("R11 reset state", 32'(pst), 0);
        chk("R11 reset violation", 32'(viol), 0);
        chk("R11 reset break", 32'(brk), 0);
        chk("R11 reset fire", 32'(fire), 0);
        chk("R11 reset vid", 32'(vid), 0);

        // R1/R2 sweep over every pair of thread codes
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                int m;
                m = (a < b) ? a : b;
                thr0 = 2'(a); thr1 = 2'(b);
                #1;
                chk("R1 request", 32'(preq), (m == 3) ? 6 : m);
                cyc();
                chk("R2 base state", 32'(pst), (m == 0) ? 0 : 1);
            end
        end

        // R3 entry from AutoHalt and return to it
        thr0 = 2'd1; thr1 = 2'd1; cyc();
        stop_n = 1'b0; cyc();
        chk("R3 no entry without ack", 32'(pst), 1);
        sga = 1'b1; cyc(); sga = 1'b0;
        chk("R3 entry", 32'(pst), 2);
        stop_n = 1'b1; cyc();
        chk("R3 return to AutoHalt", 32'(pst), 1);

        // R4/R8/R9 events in Stop-Grant entered from Normal
        thr0 = 2'd0; thr1 = 2'd0; cyc();
        chk("R2 normal", 32'(pst), 0);
        stop_n = 1'b0; sga = 1'b1; cyc(); sga = 1'b0;
        chk("R3 entry from normal", 32'(pst), 2);
        chk("R8 no break idle", 32'(brk), 0);
        src = 5'b00001; cyc();
        chk("R4 irq snoop state", 32'(pst), 3);
        chk("R8 break", 32'(brk), 1);
        src = '0; cyc();
        chk("R4 irq back", 32'(pst), 2);
        chk("R8 break held", 32'(brk), 1);
        snp = 1'b1; cyc(); snp = 1'b0;
        chk("R4 snoop state", 32'(pst), 3);
        cyc();
        chk("R4 snoop wait", 32'(pst), 3);
        snpd = 1'b1; cyc(); snpd = 1'b0;
        chk("R4 snoop done", 32'(pst), 2);
        src = 5'b10000; cyc(); src = '0;
        chk("R4 monitor snoop state", 32'(pst), 3);
        cyc();
        chk("R4 monitor back", 32'(pst), 2);
        src = 5'b00001; cyc(); src = '0;
        chk("R4 repeat irq no detour", 32'(pst), 2);
        stop_n = 1'b1; cyc();
        chk("R3 return to normal", 32'(pst), 0);
        chk("R9 fire not yet", 32'(fire), 0);
        chk("R8 break cleared", 32'(brk), 0);
        cyc();
        chk("R9 fire set", 32'(fire), 32'h11);
        cyc();
        chk("R9 fire once", 32'(fire), 0);

        // R5/R6/R7 full deep pass
        thr0 = 2'd3; thr1 = 2'd3; cyc();
        chk("R1 deeper request", 32'(preq), 6);
        stop_n = 1'b0; sga = 1'b1; cyc(); sga = 1'b0;
        chk("R3 entry from AutoHalt", 32'(pst), 2);
        slp_n = 1'b0; cyc();
        chk("R5 sleep", 32'(pst), 4);
        dslp_n = 1'b0; cyc();
        chk("R6 deep", 32'(pst), 5);
        chk("R7 vid deep", 32'(vid), 0);
        drst_n = 1'b0; cyc();
        chk("R7 deeper", 32'(pst), 6);
        chk("R7 vid deeper", 32'(vid), 1);
        wz = 1'b1; cyc();
        chk("R7 deeper enh", 32'(pst), 7);
        chk("R7 vid enh", 32'(vid), 2);
        drst_n = 1'b1; cyc();
        chk("R7 back to deep", 32'(pst), 5);
        wz = 1'b0;
        dslp_n = 1'b1;
        repeat (SETTLE - 1) cyc();
        chk("R6 still settling", 32'(pst), 5);
        cyc();
        chk("R6 settled sleep", 32'(pst), 4);
        slp_n = 1'b1; cyc();
        chk("R5 back to stop-grant", 32'(pst), 2);
        chk("R12 legal pass clean", 32'(viol), 0);

        // R10 activity in Sleep is ignored but flagged
        slp_n = 1'b0; cyc();
        chk("R5 sleep again", 32'(pst), 4);
        snp = 1'b1; src = 5'b00001; cyc(); snp = 1'b0; src = '0;
        chk("R10 state kept", 32'(pst), 4);
        chk("R10 violation", 32'(viol), 1);
        cyc();
        slp_n = 1'b1; cyc();
        chk("R10 back to stop-grant", 32'(pst), 2);
        chk("R10 nothing latched", 32'(brk), 0);
        stop_n = 1'b1; cyc();
        chk("R3 return to AutoHalt after pass", 32'(pst), 1);
        chk("R12 sticky", 32'(viol), 1);

        // R11 reset clears, R5 out-of-order sleep pin
        rst = 1'b1; cyc(); rst = 1'b0;
        chk("R11 reset clears violation", 32'(viol), 0);
        chk("R11 reset state again", 32'(pst), 0);
        thr0 = 2'd0; thr1 = 2'd0;
        slp_n = 1'b0; cyc(); slp_n = 1'b1;
        chk("R5 no sleep from normal", 32'(pst), 0);
        chk("R5 violation on early sleep", 32'(viol), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule